// File: doc/BRIEF.md
# Receive Packet Buffer with Skip and Flush Control

This block buffers received packets on their way to a host processor. A packet writer pushes 32-bit data words into a data FIFO and, once a packet is complete, pushes one status word into a separate status FIFO. The status word carries the packet length in bytes in bits [29:16] and an error flag in bit 15. The host reads the status word first and then reads the packet's data words through a read-request port. Each read port shows its head word combinationally and pops the head on the clock edge.

The block offers two host-triggered discard operations. Fast-forward skips the data words of the current packet that have not yet been read. It moves the data read pointer forward one word per clock, and its control bit clears itself when the skip is done. The status FIFO is left alone. Dump empties both FIFOs at once by returning every pointer to its reset value. Dump is accepted only while the receiver reports that it is halted. Each FIFO reports its fill level and counts writes that were dropped because the FIFO was full.

Top module: `rx_discard_fifo`

## Requirements
- R1: After reset, both levels, both overflow counters, both control bits and both sticky error flags are zero.
- R2: Data words and status words each leave their own FIFO in the order written. Each level counts the entries held. A read from an empty FIFO returns zero and changes nothing.
- R3: A write to a full FIFO is dropped. The level stays at the depth, and that FIFO's overflow counter increments, saturating at its maximum.
- R4: Reading a status word sets the current packet's remaining word count to ceil(bits[29:16] / 4). Each data word read then lowers the count by one, stopping at zero.
- R5: A fast-forward request is accepted when the remaining count is at least 4, the data FIFO holds at least that many words, and no data word is read in the same cycle. On acceptance the control bit reads 1 from the next cycle. It stays at 1 for exactly as many cycles as the remaining count, during which the data read pointer advances by one word per clock. The next data word read is then the first word after the skipped packet.
- R6: A fast-forward request that does not meet the conditions of R5 is not acted on. The control bit stays 0 and the data level is unchanged.
- R7: Fast-forward leaves the status FIFO unchanged. Status reads made during a skip return the next status word in order. A status word read during a skip sets the remaining count for the following packet once the skip ends.
- R8: While fast-forward is busy, a data read returns zero, pops nothing, and sets a sticky read-error flag.
- R9: Data words written during a fast-forward are stored and are not skipped.
- R10: A dump request while the receiver-halted input is 1 sets the dump bit for one cycle. After that cycle both levels are zero and the dump bit reads 0.
- R11: A dump request while the receiver-halted input is 0 is ignored. Both levels are unchanged, the dump bit stays 0, and a sticky dump-error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_valid | input | 1 | Push one data word |
| wr_data | input | 32 | Data word to push |
| wr_stat_valid | input | 1 | Push one status word |
| wr_stat | input | 32 | Status word: length in bytes in [29:16], error flag in [15] |
| rd_data_req | input | 1 | Host data read; pops the head word on the clock edge |
| rd_data | output | 32 | Head data word, or zero when empty or blocked |
| rd_stat_req | input | 1 | Host status read; pops the head entry on the clock edge |
| rd_stat | output | 32 | Head status word, or zero when empty |
| ffwd_req | input | 1 | Request a fast-forward of the current packet |
| dump_req | input | 1 | Request a flush of both FIFOs |
| rx_halted | input | 1 | Receiver is stopped |
| ffwd_busy | output | 1 | Fast-forward control bit; clears itself |
| dump_busy | output | 1 | Dump control bit; clears itself |
| data_level | output | DAW+1 | Data words held |
| stat_level | output | SAW+1 | Status entries held |
| data_ovf | output | OVF_W | Dropped data writes |
| stat_ovf | output | OVF_W | Dropped status writes |
| rd_err | output | 1 | Sticky: data read attempted during fast-forward |
| dump_err | output | 1 | Sticky: dump requested while the receiver was running |

## Verification
The assertions assume that every status word pushed follows all of its packet's data words, so a packet counted by the remaining-word logic is always fully present when a skip starts. They also assume that no writer pushes data while a dump is in progress, because the receiver is halted then. The bench keeps to these assumptions: it writes each packet's data before its status, and it drives no writes while the halted input is raised for a dump. Its one concurrent write during a skip goes to the data FIFO with no status word attached.

// File: rtl/rx_discard_fifo.sv
module rx_discard_fifo #(
  parameter int DATA_DEPTH = 32,
  parameter int STAT_DEPTH = 8,
  parameter int MIN_SKIP   = 4,
  parameter int OVF_W      = 8,
  localparam int DAW = $clog2(DATA_DEPTH),
  localparam int SAW = $clog2(STAT_DEPTH),
  localparam int LW  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_valid,
  input  logic [31:0]      wr_data,
  input  logic             wr_stat_valid,
  input  logic [31:0]      wr_stat,
  input  logic             rd_data_req,
  output logic [31:0]      rd_data,
  input  logic             rd_stat_req,
  output logic [31:0]      rd_stat,
  input  logic             ffwd_req,
  input  logic             dump_req,
  input  logic             rx_halted,
  output logic             ffwd_busy,
  output logic             dump_busy,
  output logic [DAW:0]     data_level,
  output logic [SAW:0]     stat_level,
  output logic [OVF_W-1:0] data_ovf,
  output logic [OVF_W-1:0] stat_ovf,
  output logic             rd_err,
  output logic             dump_err
);

  logic [31:0] dmem [DATA_DEPTH];
  logic [31:0] smem [STAT_DEPTH];
  logic [DAW:0] dwp, drp;
  logic [SAW:0] swp, srp;
  logic [LW-1:0] rem, pend;
  logic pend_v;

  assign data_level = dwp - drp;
  assign stat_level = swp - srp;

  wire d_empty = data_level == '0;
  wire s_empty = stat_level == '0;
  wire d_full  = 32'(data_level) == DATA_DEPTH;
  wire s_full  = 32'(stat_level) == STAT_DEPTH;

  wire d_push = wr_data_valid && !dump_busy && !d_full;
  wire s_push = wr_stat_valid && !dump_busy && !s_full;
  wire d_pop  = rd_data_req && !ffwd_busy && !dump_busy && !d_empty;
  wire s_pop  = rd_stat_req && !dump_busy && !s_empty;
  wire skip   = ffwd_busy && !dump_busy && !d_empty;

  assign rd_data = (ffwd_busy || dump_busy || d_empty) ? 32'd0 : dmem[drp[DAW-1:0]];
  assign rd_stat = (dump_busy || s_empty) ? 32'd0 : smem[srp[SAW-1:0]];

  wire [14:0]   len_p3  = {1'b0, rd_stat[29:16]} + 15'd3;
  wire [LW-1:0] s_words = {1'b0, len_p3[14:2]};

  wire ffwd_acc = ffwd_req && !ffwd_busy && !dump_busy && !d_pop &&
                  32'(rem) >= MIN_SKIP && 32'(data_level) >= 32'(rem);

  always_ff @(posedge clk) begin
    if (d_push) dmem[dwp[DAW-1:0]] <= wr_data;
    if (s_push) smem[swp[SAW-1:0]] <= wr_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwp <= '0; drp <= '0; swp <= '0; srp <= '0;
      data_ovf <= '0; stat_ovf <= '0;
      dump_busy <= 1'b0; dump_err <= 1'b0; rd_err <= 1'b0;
    end else begin
      dump_busy <= dump_req && rx_halted && !dump_busy;
      if (dump_req && !rx_halted) dump_err <= 1'b1;
      if (rd_data_req && ffwd_busy && !dump_busy) rd_err <= 1'b1;
      if (wr_data_valid && !dump_busy && d_full && data_ovf != '1) data_ovf <= data_ovf + 1'b1;
      if (wr_stat_valid && !dump_busy && s_full && stat_ovf != '1) stat_ovf <= stat_ovf + 1'b1;
      if (dump_busy) begin
        dwp <= '0; drp <= '0; swp <= '0; srp <= '0;
      end else begin
        if (d_push) dwp <= dwp + 1'b1;
        if (s_push) swp <= swp + 1'b1;
        if (s_pop)  srp <= srp + 1'b1;
        if (d_pop || skip) drp <= drp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; pend <= '0; pend_v <= 1'b0; ffwd_busy <= 1'b0;
    end else if (dump_busy) begin
      rem <= '0; pend_v <= 1'b0; ffwd_busy <= 1'b0;
    end else if (ffwd_busy) begin
      if (rem == LW'(1)) begin
        ffwd_busy <= 1'b0;
        pend_v    <= 1'b0;
        rem <= s_pop ? s_words : (pend_v ? pend : '0);
      end else begin
        rem <= rem - 1'b1;
        if (s_pop) begin pend <= s_words; pend_v <= 1'b1; end
      end
    end else if (ffwd_acc) begin
      ffwd_busy <= 1'b1;
      if (s_pop) begin pend <= s_words; pend_v <= 1'b1; end
    end else if (s_pop) begin
      rem <= s_words;
    end else if (d_pop && rem != '0) begin
      rem <= rem - 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(data_level) <= DATA_DEPTH && 32'(stat_level) <= STAT_DEPTH);

  // R5
  ffwd_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffwd_busy |-> rem != '0);

  // R6
  ffwd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffwd_req && !ffwd_busy && 32'(rem) < MIN_SKIP) |=> !ffwd_busy);

  // R7
  ffwd_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffwd_busy && !dump_busy && !wr_stat_valid && !rd_stat_req) |=> $stable(stat_level));

  // R8
  ffwd_rderr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffwd_busy && rd_data_req && !dump_busy) |=> rd_err);

  // R10
  dump_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_busy |=> (data_level == '0 && stat_level == '0 && !dump_busy));

  // R11
  dump_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_req && !rx_halted && !dump_busy) |=> (!dump_busy && dump_err));

endmodule

// File: tb/sim_rx_discard_fifo.sv
module sim_rx_discard_fifo;
  localparam int DD = 32, SD = 8;

  logic clk = 0, rst_n = 0;
  logic wr_data_valid = 0, wr_stat_valid = 0, rd_data_req = 0, rd_stat_req = 0;
  logic ffwd_req = 0, dump_req = 0, rx_halted = 0;
  logic [31:0] wr_data = 0, wr_stat = 0, rd_data, rd_stat;
  logic ffwd_busy, dump_busy, rd_err, dump_err;
  logic [5:0] data_level;
  logic [3:0] stat_level;
  logic [7:0] data_ovf, stat_ovf;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rx_discard_fifo #(.DATA_DEPTH(DD), .STAT_DEPTH(SD)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_d(input logic [31:0] w);
    wr_data_valid = 1; wr_data = w; tick(); wr_data_valid = 0;
  endtask

  task automatic push_s(input int bytes);
    wr_stat_valid = 1; wr_stat = {2'b0, 14'(bytes), 16'h0}; tick(); wr_stat_valid = 0;
  endtask

  task automatic pop_d(output logic [31:0] w);
    rd_data_req = 1; #1 w = rd_data; tick(); rd_data_req = 0;
  endtask

  task automatic pop_s(output logic [31:0] w);
    rd_stat_req = 1; #1 w = rd_stat; tick(); rd_stat_req = 0;
  endtask

  task automatic do_dump();
    rx_halted = 1; dump_req = 1; tick(); dump_req = 0; tick(); rx_halted = 0;
  endtask

  task automatic t_reset();
    chk(data_level == 0 && stat_level == 0, "R1 levels", int'(data_level), 0);
    chk(!ffwd_busy && !dump_busy && !rd_err && !dump_err, "R1 bits", int'(ffwd_busy), 0);
    chk(data_ovf == 0 && stat_ovf == 0, "R1 ovf", int'(data_ovf), 0);
  endtask

  task automatic t_order();
    logic [31:0] w;
    for (int i = 0; i < 3; i++) push_d(32'hA0 + i);
    push_s(12); push_s(40);
    chk(data_level == 3, "R2 data level", int'(data_level), 3);
    chk(stat_level == 2, "R2 stat level", int'(stat_level), 2);
    pop_s(w); chk(w[29:16] == 12, "R2 stat order", int'(w[29:16]), 12);
    pop_s(w); chk(w[29:16] == 40, "R2 stat order", int'(w[29:16]), 40);
    for (int i = 0; i < 3; i++) begin
      pop_d(w); chk(w == 32'hA0 + i, "R2 data order", int'(w), 32'hA0 + i);
    end
    pop_d(w); chk(w == 0 && data_level == 0, "R2 empty read", int'(w), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DD + 1; i++) push_d(i);
    chk(data_level == DD, "R3 data full level", int'(data_level), DD);
    chk(data_ovf == 1, "R3 data ovf", int'(data_ovf), 1);
    for (int i = 0; i < SD + 2; i++) push_s(4);
    chk(stat_ovf == 2, "R3 stat ovf", int'(stat_ovf), 2);
    do_dump();
  endtask

  task automatic t_ffwd();
    logic [31:0] w;
    int cnt;
    for (int i = 0; i < 6; i++) push_d(32'h100 + i);
    push_s(22);
    for (int i = 0; i < 2; i++) push_d(32'h200 + i);
    push_s(8);
    pop_s(w);
    pop_d(w); chk(w == 32'h100, "R4 first word", int'(w), 32'h100);
    ffwd_req = 1; tick(); ffwd_req = 0;
    chk(ffwd_busy == 1, "R5 bit set", int'(ffwd_busy), 1);
    rd_data_req = 1; rd_stat_req = 1; wr_data_valid = 1; wr_data = 32'h300;
    #1;
    chk(rd_data == 0, "R8 zero during skip", int'(rd_data), 0);
    chk(rd_stat[29:16] == 8, "R7 status during skip", int'(rd_stat[29:16]), 8);
    tick(); rd_data_req = 0; rd_stat_req = 0; wr_data_valid = 0;
    cnt = 1;
    while (ffwd_busy && cnt < 50) begin tick(); cnt++; end
    chk(cnt == 5, "R5 busy cycles", cnt, 5);
    chk(rd_err == 1, "R8 sticky err", int'(rd_err), 1);
    chk(data_level == 3, "R9 level after skip", int'(data_level), 3);
    chk(stat_level == 0, "R7 stat level", int'(stat_level), 0);
    pop_d(w); chk(w == 32'h200, "R5 next packet", int'(w), 32'h200);
    pop_d(w); chk(w == 32'h201, "R2 next packet", int'(w), 32'h201);
    pop_d(w); chk(w == 32'h300, "R9 written during skip", int'(w), 32'h300);
  endtask

  task automatic t_ffwd_short();
    logic [31:0] w;
    for (int i = 0; i < 3; i++) push_d(32'h400 + i);
    push_s(12);
    pop_s(w);
    ffwd_req = 1; tick(); ffwd_req = 0;
    chk(ffwd_busy == 0, "R6 refused", int'(ffwd_busy), 0);
    chk(data_level == 3, "R6 level kept", int'(data_level), 3);
    for (int i = 0; i < 3; i++) begin
      pop_d(w); chk(w == 32'h400 + i, "R6 drain", int'(w), 32'h400 + i);
    end
  endtask

  task automatic t_dump();
    push_d(32'h55); push_d(32'h56); push_s(8);
    rx_halted = 0; dump_req = 1; tick(); dump_req = 0;
    chk(dump_busy == 0, "R11 ignored", int'(dump_busy), 0);
    chk(data_level == 2 && stat_level == 1, "R11 levels kept", int'(data_level), 2);
    chk(dump_err == 1, "R11 sticky err", int'(dump_err), 1);
    rx_halted = 1; dump_req = 1; tick(); dump_req = 0;
    chk(dump_busy == 1, "R10 bit set", int'(dump_busy), 1);
    tick(); rx_halted = 0;
    chk(dump_busy == 0, "R10 self clear", int'(dump_busy), 0);
    chk(data_level == 0 && stat_level == 0, "R10 emptied", int'(data_level), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_overflow();
    t_ffwd();
    t_ffwd_short();
    t_dump();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule